// File: doc/BRIEF.md
# Video Pixel Link Serializer

This block turns one parallel video pixel per pixel period into a serial bit stream carried on one, two or three data lanes. A pixel holds three 8-bit colour fields, three sync and control bits (horizontal sync, vertical sync, data enable) and two auxiliary bits. The block adds an even parity bit over the colour and sync bits, giving a 30-bit word. That word is dealt out bit by bit across the active lanes.

The block runs entirely on the bit clock, which must be supplied at the pixel rate times the bits per lane. It times each pixel period itself and samples the pixel inputs and the lane-mode input once, at the edge that starts a pixel. Alongside the lanes it drives two signals. A framing strobe marks the first bit of each pixel. A forwarded pixel clock is high during the first half of each pixel period, so that its rising edge lines up with the start of the pixel.

Top module: `pixel_link_ser`

## Requirements
- R1: The 30-bit word is sent first-bit-first in this order: red[7:0], green[7:0], blue[7:0], hsync, vsync, data enable, aux[1:0], parity. Each field is sent with its most significant bit first.
- R2: The parity bit is even over the 24 colour bits and the three sync/control bits. The XOR of those 27 bits and the parity bit is 0. The auxiliary bits do not affect parity.
- R3: `lane_mode` selects the lane count: 00 gives one lane, 01 gives two lanes, 10 gives three lanes, and 11 is treated as three lanes. Word bit k (k = 0 is sent first) goes on lane k mod N in bit slot floor(k / N) of the pixel.
- R4: Lanes with an index at or above the active lane count stay at 0 for the whole pixel.
- R5: A pixel lasts 30/N bit clocks: 30, 15 or 10. The first pixel starts at the first clock edge with reset released. Each later pixel starts right after the previous one ends.
- R6: `pix_start` is 1 exactly during the first bit slot of each pixel and 0 otherwise.
- R7: `pix_clk_out` is 1 during the first ceil(S/2) bit slots of each pixel, where S is the slot count, and 0 for the rest.
- R8: The pixel inputs and `lane_mode` are sampled only at the edge that starts a pixel. Changes made while a pixel is being sent do not affect that pixel.
- R9: While `rst_n` is low at a clock edge, all outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_mode | input | 2 | Lane-count select (00/01/10/11) |
| pix_red | input | 8 | Red component |
| pix_green | input | 8 | Green component |
| pix_blue | input | 8 | Blue component |
| pix_hsync | input | 1 | Horizontal sync |
| pix_vsync | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| pix_aux | input | 2 | Auxiliary bits, not covered by parity |
| lane_out | output | 3 | Serial data lanes, lane 0 at bit 0 |
| pix_start | output | 1 | First-bit-of-pixel strobe |
| pix_clk_out | output | 1 | Forwarded pixel clock |

## Verification
The hardest case to reach from the ports is a change of lane mode or pixel data while a pixel is in flight. The change must leave that pixel untouched and take effect exactly at the next boundary, whose timing itself depends on the old mode. The stimulus tracks each pixel boundary from the slot count it expects. Partway through a pixel it scrambles both the data and the mode, then restores the intended next values just before the boundary. Consecutive pixels switch between all four mode codes, so each pixel period length follows one of a different length. Pixels that differ only in their auxiliary bits confirm that the parity slot stays the same.

// File: rtl/vps_pkg.sv
// Shared lane-mode encoding and helpers for the pixel link serializer.
package vps_pkg;

    typedef enum logic [1:0] {
        LM_ONE   = 2'b00,
        LM_TWO   = 2'b01,
        LM_THREE = 2'b10,
        LM_RSVD  = 2'b11
    } lane_mode_e;

    // Number of active lanes for a mode code; the reserved code maps to three.
    function automatic logic [1:0] lane_count(input logic [1:0] mode);
        case (lane_mode_e'(mode))
            LM_ONE:  lane_count = 2'd1;
            LM_TWO:  lane_count = 2'd2;
            default: lane_count = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/vps_pack.sv
// vps_pack: builds the serial word from one pixel.
// Order, first-sent at the MSB: red, green, blue, hsync, vsync, de, aux, parity.
// Assumes the parity bit is even over the colour and sync bits only.
module vps_pack #(
    parameter int COLOR_W = 8,
    parameter int AUX_W   = 2,
    localparam int WORD_W = 3 * COLOR_W + 3 + AUX_W + 1
) (
    input  logic [COLOR_W-1:0] red,
    input  logic [COLOR_W-1:0] green,
    input  logic [COLOR_W-1:0] blue,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               de,
    input  logic [AUX_W-1:0]   aux,
    output logic [WORD_W-1:0]  word
);

    logic parity;

    // Even parity over colour and sync bits; aux excluded.
    always_comb begin
        parity = ^{red, green, blue, hsync, vsync, de};
        word   = {red, green, blue, hsync, vsync, de, aux, parity};
    end

endmodule

// File: rtl/vps_timing.sv
// vps_timing: bit counter that delimits pixel periods on the bit clock.
// Samples the lane mode at each pixel boundary and produces the load pulse,
// the first-bit strobe and the forwarded pixel clock.
// Assumes WORD_W >= 4, so every pixel lasts at least two bit slots.
module vps_timing #(
    parameter int WORD_W = 30,
    localparam int CW    = $clog2(WORD_W)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_in,
    output logic       load,
    output logic [1:0] nl_next,
    output logic [1:0] nl_cur,
    output logic       strobe,
    output logic       pclk
);
    import vps_pkg::*;

    localparam int S1 = WORD_W;
    localparam int S2 = (WORD_W + 1) / 2;
    localparam int S3 = (WORD_W + 2) / 3;
    localparam logic [CW-1:0] LAST1 = CW'(S1 - 1);
    localparam logic [CW-1:0] LAST2 = CW'(S2 - 1);
    localparam logic [CW-1:0] LAST3 = CW'(S3 - 1);
    localparam logic [CW-1:0] HALF1 = CW'((S1 + 1) / 2);
    localparam logic [CW-1:0] HALF2 = CW'((S2 + 1) / 2);
    localparam logic [CW-1:0] HALF3 = CW'((S3 + 1) / 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_slot;
    logic [CW-1:0] half_slot;
    logic          valid_q;
    logic [1:0]    nl_q;

    // Last slot and pixel-clock high length for the lane count in use.
    always_comb begin
        case (nl_q)
            2'd1:    begin last_slot = LAST1; half_slot = HALF1; end
            2'd2:    begin last_slot = LAST2; half_slot = HALF2; end
            default: begin last_slot = LAST3; half_slot = HALF3; end
        endcase
    end

    // Boundary detection and output strobes.
    always_comb begin
        load    = !valid_q || (cnt == last_slot);
        nl_next = lane_count(mode_in);
        nl_cur  = nl_q;
        strobe  = valid_q && (cnt == '0);
        pclk    = valid_q && (cnt < half_slot);
    end

    // Slot counter; lane count latched only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            valid_q <= 1'b0;
            nl_q    <= 2'd1;
        end else if (load) begin
            cnt     <= '0;
            valid_q <= 1'b1;
            nl_q    <= nl_next;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_slot);
    assert_pclk_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pclk) |-> strobe);
    assert_boundary_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(load));

endmodule

// File: rtl/vps_lane.sv
// vps_lane: one output lane's shift register.
// On load it picks the word bits LANE, LANE+N, LANE+2N, ... into slot order.
// A lane at or above the active count loads all zeros. Assumes N is 1 to 3.
module vps_lane #(
    parameter int WORD_W = 30,
    parameter int LANE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        nl,
    input  logic [WORD_W-1:0] word,
    output logic              bit_out
);

    logic [WORD_W-1:0] image;
    logic [WORD_W-1:0] sreg;

    // Gather this lane's bits round-robin; slot 0 lands at the MSB.
    always_comb begin
        int n;
        int k;
        n = int'(nl);
        for (int s = 0; s < WORD_W; s++) begin
            k = s * n + LANE;
            if (LANE < n && k < WORD_W)
                image[WORD_W-1-s] = word[WORD_W-1-k];
            else
                image[WORD_W-1-s] = 1'b0;
        end
    end

    // Load a fresh image at a boundary, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg <= '0;
        else if (load)
            sreg <= image;
        else
            sreg <= {sreg[WORD_W-2:0], 1'b0};
    end

    assign bit_out = sreg[WORD_W-1];

endmodule

// File: rtl/pixel_link_ser.sv
// pixel_link_ser: pixel-to-serial link transmitter on the bit clock.
// Packs a pixel with even parity and spreads it over 1 to 3 lanes.
// It also drives a first-bit strobe and a forwarded pixel clock.
// Assumes the bit clock runs at the pixel rate times the slots per lane,
// and that the pixel inputs are valid at each boundary edge.
module pixel_link_ser #(
    parameter int COLOR_W = 8,
    parameter int AUX_W   = 2,
    localparam int WORD_W = 3 * COLOR_W + 3 + AUX_W + 1,
    localparam int LANES  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         lane_mode,
    input  logic [COLOR_W-1:0] pix_red,
    input  logic [COLOR_W-1:0] pix_green,
    input  logic [COLOR_W-1:0] pix_blue,
    input  logic               pix_hsync,
    input  logic               pix_vsync,
    input  logic               pix_de,
    input  logic [AUX_W-1:0]   pix_aux,
    output logic [LANES-1:0]   lane_out,
    output logic               pix_start,
    output logic               pix_clk_out
);

    logic [WORD_W-1:0] word;
    logic              load;
    logic [1:0]        nl_next;
    logic [1:0]        nl_cur;

    vps_pack #(.COLOR_W(COLOR_W), .AUX_W(AUX_W)) u_pack (
        .red   (pix_red),
        .green (pix_green),
        .blue  (pix_blue),
        .hsync (pix_hsync),
        .vsync (pix_vsync),
        .de    (pix_de),
        .aux   (pix_aux),
        .word  (word)
    );

    vps_timing #(.WORD_W(WORD_W)) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (lane_mode),
        .load    (load),
        .nl_next (nl_next),
        .nl_cur  (nl_cur),
        .strobe  (pix_start),
        .pclk    (pix_clk_out)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vps_lane #(.WORD_W(WORD_W), .LANE(l)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .nl      (nl_next),
            .word    (word),
            .bit_out (lane_out[l])
        );

        assert_unused_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (l >= int'(nl_cur)) |-> (lane_out[l] == 1'b0));
    end

endmodule

// File: tb/pixel_link_ser_bench.sv
// Scoreboard bench: drive_pixel queues the expected per-slot outputs of
// each pixel and a monitor compares them one slot after each clock edge.
module pixel_link_ser_bench;

    typedef struct {
        logic [2:0] lanes;
        logic [2:0] used;
        logic       strobe;
        logic       pclk;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lane_mode = 2'b00;
    logic [7:0] pix_red = '0, pix_green = '0, pix_blue = '0;
    logic       pix_hsync = 1'b0, pix_vsync = 1'b0, pix_de = 1'b0;
    logic [1:0] pix_aux = '0;
    logic [2:0] lane_out;
    logic       pix_start, pix_clk_out;

    int checks = 0;
    int errors = 0;
    item_t q[$];

    always #2.5 clk = ~clk;

    pixel_link_ser u_pixel_link_ser (
        .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
        .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de),
        .pix_aux(pix_aux), .lane_out(lane_out), .pix_start(pix_start),
        .pix_clk_out(pix_clk_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: one expected slot per clock, sampled 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check((lane_out & it.used) == (it.lanes & it.used), it.tag,
                  int'(lane_out & it.used), int'(it.lanes & it.used));
            check((lane_out & ~it.used) == 3'b000, "R4 unused lanes",
                  int'(lane_out & ~it.used), 0);
            check(pix_start == it.strobe, "R5 R6 strobe", int'(pix_start), int'(it.strobe));
            check(pix_clk_out == it.pclk, "R7 pixel clock", int'(pix_clk_out), int'(it.pclk));
        end
    end

    // Driver: called at the falling edge before a pixel boundary.
    task automatic drive_pixel(input logic [7:0] r, g, b, input logic [2:0] ctl,
                               input logic [1:0] a, input logic [1:0] m,
                               input string tag, input bit scramble);
        logic [29:0] w;
        logic        par;
        int          n, s_cnt;
        pix_red = r; pix_green = g; pix_blue = b;
        {pix_hsync, pix_vsync, pix_de} = ctl;
        pix_aux = a; lane_mode = m;
        par   = ^{r, g, b, ctl};                    // R2 even parity, aux excluded
        w     = {r, g, b, ctl, a, par};             // R1 order
        n     = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 3;  // R3 encoding
        s_cnt = (30 + n - 1) / n;                   // R5 slot count
        for (int s = 0; s < s_cnt; s++) begin
            item_t it;
            it.lanes = 3'b000;
            it.used  = 3'b000;
            for (int l = 0; l < n; l++) begin
                int k;
                k = s * n + l;
                it.used[l] = 1'b1;
                if (k < 30) it.lanes[l] = w[29 - k];
            end
            it.strobe = (s == 0);
            it.pclk   = (s < (s_cnt + 1) / 2);
            it.tag    = tag;
            q.push_back(it);
        end
        for (int i = 0; i < s_cnt; i++) begin
            @(negedge clk);
            if (scramble && i == 2) begin           // R8 mid-pixel changes
                pix_red = ~r; pix_green = ~g; pix_blue = ~b;
                {pix_hsync, pix_vsync, pix_de} = ~ctl;
                pix_aux = ~a; lane_mode = m ^ 2'b01;
            end
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: outputs quiet during reset
        check(lane_out == 3'b000, "R9 lanes in reset", int'(lane_out), 0);
        check(pix_start == 1'b0, "R9 strobe in reset", int'(pix_start), 0);
        check(pix_clk_out == 1'b0, "R9 pixel clock in reset", int'(pix_clk_out), 0);
        rst_n = 1'b1;
        drive_pixel(8'hA5, 8'h3C, 8'hF0, 3'b101, 2'b10, 2'b00, "R1 one lane", 0);
        drive_pixel(8'h81, 8'h7E, 8'h00, 3'b011, 2'b01, 2'b00, "R1 one lane", 0);
        drive_pixel(8'h12, 8'h34, 8'h56, 3'b001, 2'b00, 2'b00, "R2 parity aux 00", 0);
        drive_pixel(8'h12, 8'h34, 8'h56, 3'b001, 2'b11, 2'b00, "R2 parity aux 11", 0);
        drive_pixel(8'hC3, 8'h5A, 8'h99, 3'b110, 2'b01, 2'b01, "R3 two lanes", 0);
        drive_pixel(8'hFF, 8'hFF, 8'hFF, 3'b111, 2'b11, 2'b10, "R3 three lanes", 0);
        drive_pixel(8'h0F, 8'hE1, 8'h2D, 3'b010, 2'b10, 2'b11, "R3 reserved as three", 0);
        drive_pixel(8'h6B, 8'h92, 8'h47, 3'b100, 2'b01, 2'b01, "R8 two lanes scrambled", 1);
        drive_pixel(8'h00, 8'h00, 8'h01, 3'b000, 2'b00, 2'b10, "R8 three lanes scrambled", 1);
        drive_pixel(8'hDE, 8'hAD, 8'hBE, 3'b011, 2'b10, 2'b00, "R8 one lane scrambled", 1);
        drive_pixel(8'h55, 8'hAA, 8'h33, 3'b101, 2'b11, 2'b01, "R3 two lanes after one", 0);
        wait (q.size() == 0);
        @(posedge clk);
        #2;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule